// File: doc/BRIEF.md
# Clustered Programmable Logic Fabric

A small spatially programmable logic array. The gates are grouped into clusters. Each gate is a two-input programmable function, built as a four-entry lookup mux whose data bits are its truth table. Inside a cluster, a local crossbar picks each gate input from the cluster's inputs or from the outputs of earlier gates in the same cluster. An output crossbar picks a few gate results to leave the cluster. A global routing crossbar feeds every cluster input from a primary input or from an exported output of an earlier cluster. A final selector takes the primary outputs from the exported cluster outputs.

Routing works on two levels. Only the limited cluster I/O crosses the global crossbar, so the fabric needs far fewer switches than one flat full crossbar. Sources are ordered: a gate can see only the gates before it, and a cluster can see only the clusters before it. Every configured netlist is therefore acyclic by construction.

Every select and every truth table sits in one configuration chain. The chain is loaded serially before use. After loading, the fabric works combinationally from `pi_i` to `po_o`. With defaults the fabric has 32 gates (4 clusters of 8), 2 inputs and 2 outputs per cluster, 4 primary inputs and 4 primary outputs, and a 452-bit chain.

Top module: `clf_fabric`

## Requirements
- R1: A gate outputs `tt[{b,a}]`, where `tt` is its 4-bit truth table, `a` is its first input and `b` is its second. Examples: 4'b1000 gives AND, 4'b1110 gives OR, 4'b0110 gives XOR, and 4'b0001 on a gate with both inputs tied to one signal gives NOT.
- R2: A gate-input select value s picks cluster input s when s < CI. It picks the output of gate s-CI when that gate comes before the selecting gate. Any other value reads 0, including the gate's own index, a later gate, and values of CI+CG or more.
- R3: Export select value g for a cluster output picks gate g of that cluster.
- R4: A routing select value r for a cluster input picks primary input r when r < NUM_PI. A value r = NUM_PI + c*CO + o picks output o of cluster c when c is below the receiving cluster. Any other value reads 0.
- R5: A primary-output select value q picks output q%CO of cluster q/CO.
- R6: On each `clk_i` rising edge with `cfg_en_i` high, the chain shifts up one bit and takes `cfg_data_i` into bit 0. With `cfg_en_i` low, the chain holds whatever `cfg_data_i` does.
- R7: Chain layout, from bit 0 upward. First come NC cluster blocks of 102 bits each. In a block, gate j uses 12 bits at 12*j: the truth table in [3:0], the first-input select in [7:4] and the second-input select in [11:8]. The two 3-bit export selects follow at 96 and 99. Next come eight 4-bit routing selects at 408 + 4*(2*c+i) for cluster c, input i. Last come four 3-bit output selects at 440 + 3*p.
- R8: The asynchronous reset `rst_ni` clears the whole chain, so every primary output reads 0 after reset.
- R9: While `cfg_en_i` is high, `po_o` is 0.
- R10: Once loaded, `po_o` follows `pi_i` combinationally, with no clock edge between them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Configuration shift clock |
| rst_ni | input | 1 | Asynchronous active-low reset, clears the chain |
| cfg_en_i | input | 1 | Shift enable; forces outputs to zero |
| cfg_data_i | input | 1 | Serial configuration bit |
| pi_i | input | NUM_PI | Primary inputs |
| po_o | output | NUM_PO | Primary outputs |

## Verification
The assertions assume three things about the inputs. `pi_i` is settled at each rising edge where it counts. The configuration changes only through enabled shifts. The stable-output property applies only when neither `pi_i` nor the chain has moved over the past cycle. The stimulus meets these assumptions by changing `pi_i` and `cfg_data_i` only just after a rising edge. It drops `cfg_en_i` once a full image is in place. It also drives random serial data with the enable low, to show that the chain ignores it.

// File: rtl/clf_pkg.sv
`timescale 1ns/1ps
package clf_pkg;
  // select width for an n-source crossbar output
  function automatic int sel_w(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/clf_gate.sv
`timescale 1ns/1ps
module clf_gate (
  input  logic       a_i,
  input  logic       b_i,
  input  logic [3:0] tt_i,
  output logic       y_o
);
  logic lo, hi;
  // first input picks inside each pair, second picks the pair
  assign lo  = a_i ? tt_i[1] : tt_i[0];
  assign hi  = a_i ? tt_i[3] : tt_i[2];
  assign y_o = b_i ? hi : lo;
endmodule

// File: rtl/clf_xbar.sv
`timescale 1ns/1ps
module clf_xbar #(
  parameter  int NSRC = 4,
  parameter  int NSNK = 1,
  localparam int SW   = clf_pkg::sel_w(NSRC),
  localparam int PADN = 1 << SW
) (
  input  logic [NSRC-1:0]    src_i,
  input  logic [NSNK*SW-1:0] sel_i,
  output logic [NSNK-1:0]    dst_o
);
  logic [PADN-1:0] pad;
  // unused select codes land on zero padding
  assign pad = PADN'(src_i);
  for (genvar k = 0; k < NSNK; k++) begin : g_snk
    assign dst_o[k] = pad[sel_i[k*SW +: SW]];
  end
endmodule

// File: rtl/clf_cluster.sv
`timescale 1ns/1ps
module clf_cluster #(
  parameter  int CG     = 8,
  parameter  int CI     = 2,
  parameter  int CO     = 2,
  localparam int LSRC   = CI + CG,
  localparam int LSEL_W = clf_pkg::sel_w(LSRC),
  localparam int GATE_W = 4 + 2 * LSEL_W,
  localparam int OSEL_W = clf_pkg::sel_w(CG),
  localparam int CL_W   = CG * GATE_W + CO * OSEL_W
) (
  input  logic [CI-1:0]   cin_i,
  input  logic [CL_W-1:0] cfg_i,
  output logic [CO-1:0]   cout_o
);
  logic [CG-1:0] gate_y;

  for (genvar j = 0; j < CG; j++) begin : g_gate
    logic [CG-1:0] prior;  // outputs of gates before j, zero elsewhere
    logic [1:0]    ab;
    logic          y;
    if (j == 0) begin : g_head
      assign prior = '0;
    end else begin : g_tail
      assign prior = g_gate[j-1].prior | (CG'(g_gate[j-1].y) << (j - 1));
    end
    clf_xbar #(.NSRC(LSRC), .NSNK(2)) u_in (
      .src_i ({prior, cin_i}),
      .sel_i (cfg_i[j*GATE_W+4 +: 2*LSEL_W]),
      .dst_o (ab)
    );
    clf_gate u_gate (
      .a_i  (ab[0]),
      .b_i  (ab[1]),
      .tt_i (cfg_i[j*GATE_W +: 4]),
      .y_o  (y)
    );
    assign gate_y[j] = y;
  end

  clf_xbar #(.NSRC(CG), .NSNK(CO)) u_out (
    .src_i (gate_y),
    .sel_i (cfg_i[CG*GATE_W +: CO*OSEL_W]),
    .dst_o (cout_o)
  );
endmodule

// File: rtl/clf_fabric.sv
`timescale 1ns/1ps
module clf_fabric #(
  parameter int G      = 32,
  parameter int CG     = 8,
  parameter int CI     = 2,
  parameter int CO     = 2,
  parameter int NUM_PI = 4,
  parameter int NUM_PO = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_en_i,
  input  logic              cfg_data_i,
  input  logic [NUM_PI-1:0] pi_i,
  output logic [NUM_PO-1:0] po_o
);
  localparam int NC     = G / CG;
  localparam int LSEL_W = clf_pkg::sel_w(CI + CG);
  localparam int GATE_W = 4 + 2 * LSEL_W;
  localparam int OSEL_W = clf_pkg::sel_w(CG);
  localparam int CL_W   = CG * GATE_W + CO * OSEL_W;
  localparam int PSRC   = NC * CO;
  localparam int MSRC   = NUM_PI + PSRC;
  localparam int MSEL_W = clf_pkg::sel_w(MSRC);
  localparam int PSEL_W = clf_pkg::sel_w(PSRC);
  localparam int M_OFF  = NC * CL_W;
  localparam int P_OFF  = M_OFF + NC * CI * MSEL_W;
  localparam int CFG_W  = P_OFF + NUM_PO * PSEL_W;

  logic [CFG_W-1:0]  cfg_q;
  logic [PSRC-1:0]   cl_all;
  logic [NUM_PO-1:0] po_raw;
  logic              past_ok;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q   <= '0;
      past_ok <= 1'b0;
    end else begin
      past_ok <= 1'b1;
      if (cfg_en_i) cfg_q <= {cfg_q[CFG_W-2:0], cfg_data_i};
    end
  end

  for (genvar c = 0; c < NC; c++) begin : g_cl
    logic [PSRC-1:0] prior;  // exports of clusters before c
    logic [CI-1:0]   cin;
    logic [CO-1:0]   cout;
    if (c == 0) begin : g_head
      assign prior = '0;
    end else begin : g_tail
      assign prior = g_cl[c-1].prior | (PSRC'(g_cl[c-1].cout) << ((c - 1) * CO));
    end
    clf_xbar #(.NSRC(MSRC), .NSNK(CI)) u_route (
      .src_i ({prior, pi_i}),
      .sel_i (cfg_q[M_OFF + c*CI*MSEL_W +: CI*MSEL_W]),
      .dst_o (cin)
    );
    clf_cluster #(.CG(CG), .CI(CI), .CO(CO)) u_cl (
      .cin_i  (cin),
      .cfg_i  (cfg_q[c*CL_W +: CL_W]),
      .cout_o (cout)
    );
    assign cl_all[c*CO +: CO] = cout;
  end

  clf_xbar #(.NSRC(PSRC), .NSNK(NUM_PO)) u_po (
    .src_i (cl_all),
    .sel_i (cfg_q[P_OFF +: NUM_PO*PSEL_W]),
    .dst_o (po_raw)
  );

  assign po_o = cfg_en_i ? '0 : po_raw;

  a_r6_hold_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cfg_en_i |=> $stable(cfg_q));
  a_r6_shift_in: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_en_i |=> cfg_q[0] == $past(cfg_data_i));
  a_r9_quiet_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_en_i |-> po_o == '0);
  a_r10_steady_out: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_ok && !cfg_en_i && !$past(cfg_en_i) && $stable(pi_i)) |-> $stable(po_o));
endmodule

// File: tb/clf_fabric_tb_top.sv
`timescale 1ns/1ps
module clf_fabric_tb_top;
  localparam int CL_W  = 102;
  localparam int M_OFF = 408;
  localparam int P_OFF = 440;
  localparam int CFG_W = 452;

  logic       clk = 1'b0;
  logic       rst_n, cfg_en, cfg_data;
  logic [3:0] pi;
  logic [3:0] po;
  logic [CFG_W-1:0] cfg;
  logic [3:0] exp_q[$];
  string      tag_q[$];
  int         n_cmp = 0, n_bad = 0;
  bit         done = 1'b0;

  always #2 clk = ~clk;

  clf_fabric dut_i (
    .clk_i(clk), .rst_ni(rst_n), .cfg_en_i(cfg_en), .cfg_data_i(cfg_data),
    .pi_i(pi), .po_o(po)
  );

  task automatic set_gate(int c, int j, logic [3:0] tt, logic [3:0] sa, logic [3:0] sb);
    cfg[c*CL_W + j*12 +: 4]     = tt;
    cfg[c*CL_W + j*12 + 4 +: 4] = sa;
    cfg[c*CL_W + j*12 + 8 +: 4] = sb;
  endtask
  task automatic set_exp(int c, int o, logic [2:0] g);
    cfg[c*CL_W + 96 + o*3 +: 3] = g;
  endtask
  task automatic set_route(int c, int i, logic [3:0] r);
    cfg[M_OFF + (c*2 + i)*4 +: 4] = r;
  endtask
  task automatic set_po(int p, logic [2:0] q);
    cfg[P_OFF + p*3 +: 3] = q;
  endtask

  // driver: apply inputs just after an edge, queue the expected output
  task automatic drive(logic [3:0] p, logic [3:0] e, string t);
    @(posedge clk); #1;
    pi = p;
    exp_q.push_back(e);
    tag_q.push_back(t);
  endtask

  task automatic load_cfg();
    for (int i = CFG_W - 1; i >= 0; i--) begin
      @(posedge clk); #1;
      cfg_en   = 1'b1;
      cfg_data = cfg[i];
      if (i % 100 == 50) begin
        pi = 4'hF;
        exp_q.push_back(4'h0);
        tag_q.push_back("R9 outputs zero while loading");
      end
    end
    @(posedge clk); #1;
    cfg_en = 1'b0;
  endtask

  function automatic logic [3:0] exp_tree(logic [3:0] p);
    logic t;
    t = (p[0] & p[1]) | (p[2] & p[3]);
    return {t, p[2] & p[3], p[0] & p[1], t};
  endfunction
  function automatic logic [3:0] exp_add(logic [3:0] p);
    logic [2:0] s;
    s = {1'b0, p[1:0]} + {1'b0, p[3:2]};
    return {~s[2], s};
  endfunction
  function automatic logic [3:0] exp_edge(logic [3:0] p);
    return {p[1], 1'b1, ~p[0], 1'b1};
  endfunction

  // monitor: compare away from the active edge
  always @(negedge clk) begin
    if (exp_q.size() != 0) begin
      logic [3:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      n_cmp++;
      if (po !== e) begin
        n_bad++;
        $display("FAIL %s: po=%b expected=%b", t, po, e);
      end
    end
  end

  initial begin
    repeat (60000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: po=%b expected=finished", po);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; cfg_en = 1'b0; cfg_data = 1'b0; pi = 4'h0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R8: cleared chain gives zero outputs for any input
    for (int v = 0; v < 16; v += 5) drive(4'(v), 4'h0, "R8 reset clears");

    // AND/OR tree: checks R1 R4 R5 R7 R10
    cfg = '0;
    set_route(0, 0, 4'd0); set_route(0, 1, 4'd1);
    set_gate(0, 0, 4'b1000, 4'd0, 4'd1); set_exp(0, 0, 3'd0);
    set_route(1, 0, 4'd2); set_route(1, 1, 4'd3);
    set_gate(1, 0, 4'b1000, 4'd0, 4'd1); set_exp(1, 0, 3'd0);
    set_route(2, 0, 4'd4); set_route(2, 1, 4'd6);
    set_gate(2, 0, 4'b1110, 4'd0, 4'd1); set_exp(2, 0, 3'd0); set_exp(2, 1, 3'd0);
    set_po(0, 3'd4); set_po(1, 3'd0); set_po(2, 3'd2); set_po(3, 3'd5);
    load_cfg();
    for (int v = 0; v < 16; v++) drive(4'(v), exp_tree(4'(v)), "R1 R4 R5 R7 R10 and/or tree");

    // R6: serial data with enable low must not disturb the chain
    for (int k = 0; k < 20; k++) begin
      @(posedge clk); #1;
      cfg_data = 1'($urandom);
    end
    for (int v = 0; v < 16; v += 3) drive(4'(v), exp_tree(4'(v)), "R6 hold when idle");

    // 2-bit adder with in-cluster inverter: checks R1 R2 R3
    cfg = '0;
    set_route(0, 0, 4'd0); set_route(0, 1, 4'd2);
    set_gate(0, 0, 4'b0110, 4'd0, 4'd1); set_gate(0, 1, 4'b1000, 4'd0, 4'd1);
    set_exp(0, 0, 3'd0); set_exp(0, 1, 3'd1);
    set_route(1, 0, 4'd1); set_route(1, 1, 4'd3);
    set_gate(1, 0, 4'b0110, 4'd0, 4'd1); set_gate(1, 1, 4'b1000, 4'd0, 4'd1);
    set_exp(1, 0, 3'd0); set_exp(1, 1, 3'd1);
    set_route(2, 0, 4'd5); set_route(2, 1, 4'd6);
    set_gate(2, 0, 4'b0110, 4'd0, 4'd1); set_gate(2, 1, 4'b1000, 4'd0, 4'd1);
    set_exp(2, 0, 3'd0); set_exp(2, 1, 3'd1);
    set_route(3, 0, 4'd9); set_route(3, 1, 4'd7);
    set_gate(3, 0, 4'b1110, 4'd0, 4'd1); set_gate(3, 1, 4'b0001, 4'd2, 4'd2);
    set_exp(3, 0, 3'd0); set_exp(3, 1, 3'd1);
    set_po(0, 3'd0); set_po(1, 3'd4); set_po(2, 3'd6); set_po(3, 3'd7);
    load_cfg();
    for (int v = 0; v < 16; v++) drive(4'(v), exp_add(4'(v)), "R1 R2 R3 adder");

    // ordering and out-of-range selects read zero: checks R2 R4
    cfg = '0;
    set_route(0, 0, 4'd8); set_route(0, 1, 4'd0);
    set_gate(0, 0, 4'b0001, 4'd15, 4'd15);
    set_gate(0, 1, 4'b0001, 4'd3, 4'd3);
    set_gate(0, 2, 4'b0001, 4'd0, 4'd1);
    set_exp(0, 0, 3'd1); set_exp(0, 1, 3'd2);
    set_gate(1, 0, 4'b0001, 4'd15, 4'd15); set_exp(1, 0, 3'd0);
    set_gate(2, 0, 4'b1111, 4'd0, 4'd0); set_exp(2, 0, 3'd0);
    set_route(3, 0, 4'd8); set_route(3, 1, 4'd1);
    set_gate(3, 0, 4'b1000, 4'd0, 4'd1); set_exp(3, 0, 3'd0);
    set_po(0, 3'd0); set_po(1, 3'd1); set_po(2, 3'd2); set_po(3, 3'd6);
    load_cfg();
    for (int v = 0; v < 16; v++) drive(4'(v), exp_edge(4'(v)), "R2 R4 ordering and range");

    repeat (3) @(posedge clk);
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule